// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout Response

This block is a down-counting watchdog that advances only on a tick-enable strobe from a slow dedicated timebase. When enabled, it loads its count from a reload input. The processor keeps it from expiring by pulsing a refresh strobe, which restarts the count from the reload value. If the count runs down to zero, the block raises one of two responses, chosen by a static select bit: a one-cycle interrupt request or a one-cycle reset request.

In interrupt mode the count is not reloaded after a timeout. It underflows to all ones and keeps counting down. A timeout status flag is set. If the timeout happens while the chip is in a low-power stop state, the block also sets a stop flag and pulses a wake-up request. A debug-hold input refreshes the counter on every cycle, so no timeout can occur while it is high. The counter value is brought out so the surrounding logic can read it.

Top module: `wdog_top`

## Requirements
- R1: After synchronous reset, `count` is 0 and `irq_req`, `rst_req`, `stop_wake`, `flag_to` and `flag_stop` are all 0.
- R2: In the first enabled cycle after `en` has been low, the counter loads `reload_val`. A value below 4 is loaded as 4.
- R3: While enabled, each cycle with `tick` high lowers `count` by one. While `en` is low, `count` holds its value whatever `tick` does.
- R4: While enabled, `refresh` reloads the counter from `reload_val`, clamped to at least 4. When `refresh` and `tick` arrive in the same cycle, the reload wins.
- R5: While `en` and `dbg_hold` are both high, the counter reloads every cycle and no `irq_req` or `rst_req` is produced.
- R6: With `resp_sel` = 1 (interrupt response), a tick that takes `count` from 1 to 0 sets `flag_to` and gives a one-cycle `irq_req`. Both appear on the same edge as the count reaching 0.
- R7: After an interrupt-mode timeout, the next tick takes `count` from 0 to 0xFFFFFF and counting continues down. There is no reload.
- R8: With `resp_sel` = 0 (reset response), a timeout gives a one-cycle `rst_req`, with no `irq_req` and no flag change. `irq_req` and `rst_req` are never high together.
- R9: An interrupt-mode timeout while `stop_mode` is high also pulses `stop_wake` for one cycle with `irq_req`, and sets `flag_stop` as well as `flag_to`.
- R10: `flag_clr` clears `flag_to` and `flag_stop`. A timeout in the same cycle as `flag_clr` leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Watchdog enable |
| tick | input | 1 | One-cycle strobe from the slow timebase |
| refresh | input | 1 | Refresh strobe from the processor |
| dbg_hold | input | 1 | Debug hold; refreshes the counter every cycle |
| stop_mode | input | 1 | High while the chip is in stop state |
| resp_sel | input | 1 | Timeout response: 1 = interrupt, 0 = reset |
| flag_clr | input | 1 | Clears both status flags |
| reload_val | input | 24 | Reload value |
| count | output | 24 | Current counter value |
| irq_req | output | 1 | One-cycle interrupt request |
| rst_req | output | 1 | One-cycle reset request |
| stop_wake | output | 1 | One-cycle stop-mode recovery request |
| flag_to | output | 1 | Timeout flag |
| flag_stop | output | 1 | Timeout-in-stop flag |

## Verification
Each result is a single register stage behind its stimulus. The load, decrement, reload, the response pulses and the flag changes all appear at the first rising edge after the inputs are applied. The bench drives inputs just after a falling edge and samples on the next falling edge, so every check reads the value one edge after its cause. Because the pulses last exactly one cycle, the bench samples again one cycle later to confirm that `irq_req`, `rst_req` and `stop_wake` have dropped while the flags remain set.

// File: rtl/wdog_pkg.sv
// wdog_pkg: shared types for the watchdog block.
// Assumes: one response-select encoding is used across all modules.
package wdog_pkg;
    typedef enum logic {
        RESP_RESET = 1'b0,
        RESP_IRQ   = 1'b1
    } resp_e;
endpackage

// File: rtl/wdog_counter.sv
// wdog_counter: the down counter with its load, refresh and debug-hold
// reload. It flags the tick that takes the count from 1 to 0.
// Assumes: tick is a one-cycle strobe synchronous to clk; reload_val is static
// between uses.
module wdog_counter #(
    parameter int CNT_W    = 24,
    parameter int MIN_LOAD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             refresh,
    input  logic             dbg_hold,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             timeout_hit
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_LOAD);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic             armed;
    logic             reload_now;
    logic [CNT_W-1:0] load_val;

    // Clamp the reload value to the smallest legal count.
    always_comb load_val = (reload_val < FLOOR) ? FLOOR : reload_val;

    // Reload on first enable, on refresh, or every cycle under debug hold.
    always_comb reload_now = en && (!armed || refresh || dbg_hold);

    // A decrement that lands on zero is a timeout.
    always_comb timeout_hit = en && !reload_now && tick && (count == ONE);

    // Counter register: a reload takes priority over a tick; hold when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            armed <= 1'b0;
        end else begin
            armed <= en;
            if (reload_now)
                count <= load_val;
            else if (en && tick)
                count <= count - ONE;
        end
    end

    assert_load_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !armed) |=> (count >= FLOOR));
    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));
    assert_refresh_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && refresh && tick) |=> (count >= FLOOR));
endmodule

// File: rtl/wdog_resp.sv
// wdog_resp: turns a timeout event into a reset or interrupt pulse, keeps the
// timeout and stop flags, and pulses the stop-mode wake request.
// Assumes: timeout_hit is never high on two consecutive cycles.
module wdog_resp
    import wdog_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  timeout_hit,
    input  resp_e resp_sel,
    input  logic  stop_mode,
    input  logic  flag_clr,
    output logic  irq_req,
    output logic  rst_req,
    output logic  stop_wake,
    output logic  flag_to,
    output logic  flag_stop
);
    logic irq_hit;

    // A timeout in interrupt mode.
    always_comb irq_hit = timeout_hit && (resp_sel == RESP_IRQ);

    // One-cycle response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req   <= 1'b0;
            rst_req   <= 1'b0;
            stop_wake <= 1'b0;
        end else begin
            irq_req   <= irq_hit;
            rst_req   <= timeout_hit && (resp_sel == RESP_RESET);
            stop_wake <= irq_hit && stop_mode;
        end
    end

    // Sticky status flags; a timeout takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_to   <= 1'b0;
            flag_stop <= 1'b0;
        end else begin
            if (irq_hit)       flag_to <= 1'b1;
            else if (flag_clr) flag_to <= 1'b0;
            if (irq_hit && stop_mode) flag_stop <= 1'b1;
            else if (flag_clr)        flag_stop <= 1'b0;
        end
    end

    assert_single_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_req, rst_req}));
    assert_irq_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> flag_to);
    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);
    assert_stop_implies_to_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_stop |-> flag_to);
    assert_wake_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wake |-> (irq_req && flag_stop));
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !timeout_hit) |=> (!flag_to && !flag_stop));
endmodule

// File: rtl/wdog_top.sv
// wdog_top: watchdog with a selectable timeout response. It joins the counter
// and the response logic.
// Assumes: tick comes from a slow timebase, already synchronised to clk;
// resp_sel is static during operation.
module wdog_top
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int MIN_LOAD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             refresh,
    input  logic             dbg_hold,
    input  logic             stop_mode,
    input  logic             resp_sel,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             irq_req,
    output logic             rst_req,
    output logic             stop_wake,
    output logic             flag_to,
    output logic             flag_stop
);
    logic  timeout_hit;
    resp_e resp_mode;

    // Map the raw select pin onto the response encoding.
    always_comb resp_mode = resp_e'(resp_sel);

    wdog_counter #(.CNT_W(CNT_W), .MIN_LOAD(MIN_LOAD)) u_counter (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .refresh(refresh),
        .dbg_hold(dbg_hold), .reload_val(reload_val), .count(count),
        .timeout_hit(timeout_hit)
    );

    wdog_resp u_resp (
        .clk(clk), .rst_n(rst_n), .timeout_hit(timeout_hit),
        .resp_sel(resp_mode), .stop_mode(stop_mode), .flag_clr(flag_clr),
        .irq_req(irq_req), .rst_req(rst_req), .stop_wake(stop_wake),
        .flag_to(flag_to), .flag_stop(flag_stop)
    );

    assert_dbg_no_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dbg_hold) |=> (!irq_req && !rst_req));
endmodule

// File: tb/wdog_top_tb.sv
module wdog_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, tick = 1'b0, refresh = 1'b0, dbg_hold = 1'b0;
    logic        stop_mode = 1'b0, resp_sel = 1'b1, flag_clr = 1'b0;
    logic [23:0] reload_val = 24'd0;
    logic [23:0] count;
    logic        irq_req, rst_req, stop_wake, flag_to, flag_stop;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    wdog_top u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .refresh(refresh),
        .dbg_hold(dbg_hold), .stop_mode(stop_mode), .resp_sel(resp_sel),
        .flag_clr(flag_clr), .reload_val(reload_val), .count(count),
        .irq_req(irq_req), .rst_req(rst_req), .stop_wake(stop_wake),
        .flag_to(flag_to), .flag_stop(flag_stop)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Inputs settle just after a falling edge; one rising edge later, sample.
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; cyc();
        end
        tick = 1'b0;
    endtask

    task automatic do_refresh(input logic [23:0] v);
        reload_val = v; refresh = 1'b1; cyc(); refresh = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "count", 32'(count), 0);
        chk("R1", "outs", {27'd0, irq_req, rst_req, stop_wake, flag_to, flag_stop}, 0);
    endtask

    task automatic t_load();
        reload_val = 24'd2; en = 1'b1; cyc();
        chk("R2", "clamped load", 32'(count), 4);
        en = 1'b0; cyc();
        reload_val = 24'd9; en = 1'b1; cyc();
        chk("R2", "reload on enable", 32'(count), 9);
    endtask

    task automatic t_tick_hold();
        ticks(3);
        chk("R3", "decrement", 32'(count), 6);
        en = 1'b0; ticks(2);
        chk("R3", "hold when off", 32'(count), 6);
        en = 1'b1; cyc();
        chk("R2", "re-enable load", 32'(count), 9);
    endtask

    task automatic t_refresh();
        ticks(2);
        chk("R3", "count before refresh", 32'(count), 7);
        tick = 1'b1; do_refresh(24'd9); tick = 1'b0;
        chk("R4", "refresh beats tick", 32'(count), 9);
        do_refresh(24'd0);
        chk("R4", "refresh clamp", 32'(count), 4);
    endtask

    task automatic t_debug();
        dbg_hold = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick = 1'b1; cyc();
            chk("R5", "held count", 32'(count), 4);
            chk("R5", "no response", {30'd0, irq_req, rst_req}, 0);
        end
        tick = 1'b0;
        reload_val = 24'd7; cyc();
        chk("R5", "reload under debug", 32'(count), 7);
        dbg_hold = 1'b0;
    endtask

    task automatic t_irq();
        resp_sel = 1'b1;
        do_refresh(24'd4);
        ticks(3);
        chk("R6", "count at one", 32'(count), 1);
        ticks(1);
        chk("R6", "count zero", 32'(count), 0);
        chk("R6", "irq pulse", 32'(irq_req), 1);
        chk("R6", "flag_to", 32'(flag_to), 1);
        chk("R8", "no rst in irq mode", 32'(rst_req), 0);
        chk("R9", "no wake outside stop", {30'd0, stop_wake, flag_stop}, 0);
        cyc();
        chk("R6", "irq dropped", 32'(irq_req), 0);
        chk("R6", "flag sticky", 32'(flag_to), 1);
        ticks(1);
        chk("R7", "wrap", 32'(count), 32'hFFFFFF);
        ticks(1);
        chk("R7", "continues", 32'(count), 32'hFFFFFE);
    endtask

    task automatic t_clear();
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
        chk("R10", "clear", {30'd0, flag_to, flag_stop}, 0);
        do_refresh(24'd4);
        ticks(3);
        flag_clr = 1'b1; ticks(1); flag_clr = 1'b0;
        chk("R10", "set wins over clear", 32'(flag_to), 1);
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
        chk("R10", "clear again", 32'(flag_to), 0);
    endtask

    task automatic t_rst();
        resp_sel = 1'b0;
        do_refresh(24'd4);
        ticks(4);
        chk("R8", "rst pulse", 32'(rst_req), 1);
        chk("R8", "no irq", 32'(irq_req), 0);
        chk("R8", "flags untouched", {30'd0, flag_to, flag_stop}, 0);
        cyc();
        chk("R8", "rst dropped", 32'(rst_req), 0);
        resp_sel = 1'b1;
    endtask

    task automatic t_stop();
        stop_mode = 1'b1;
        do_refresh(24'd4);
        ticks(4);
        chk("R9", "wake", 32'(stop_wake), 1);
        chk("R9", "irq with wake", 32'(irq_req), 1);
        chk("R9", "flags", {30'd0, flag_to, flag_stop}, 3);
        cyc();
        chk("R9", "wake dropped", 32'(stop_wake), 0);
        chk("R9", "stop flag sticky", 32'(flag_stop), 1);
        stop_mode = 1'b0;
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
        chk("R10", "clear both", {30'd0, flag_to, flag_stop}, 0);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_load();
        t_tick_hold();
        t_refresh();
        t_debug();
        t_irq();
        t_clear();
        t_rst();
        t_stop();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule